// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a conditional branch. Each request gives it a 4-bit condition selector, the processor's condition flags, the address of the instruction that follows the branch, and a signed displacement. It returns one clock later a taken indication and the address where execution goes next. If the condition holds, that address is the follow-on address plus the displacement. If it does not, the follow-on address passes through unchanged.

The displacement is read as either a short 8-bit or a long 16-bit two's-complement value, selected per request. The sum is taken modulo 2^16, so a branch may cross the top or bottom of the 64 KB space in either direction. The selector codes come in pairs: each even code names a test and the odd code one above it names the opposite test. Unsigned magnitude tests use carry and zero. Signed magnitude tests use negative, overflow and zero. The carry tests also serve as unsigned higher-or-same and lower.

Top module: `bru_unit`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `res_valid`, `taken` and `pc_out` are all zero.
- R2: `res_valid` equals `br_valid` of the previous clock. A clock with `br_valid` low leaves `taken` and `pc_out` unchanged.
- R3: Selector 0 is always taken and selector 1 is never taken, whatever the flags are.
- R4: For every selector pair (2k, 2k+1) and every flag value, exactly one of the two codes is taken.
- R5: Unsigned magnitude: selector 2 (higher) is taken when C=0 and Z=0. Selector 3 (lower or same) is taken when C=1 or Z=1. After a compare of a with b, this means higher is taken exactly when a > b unsigned.
- R6: Single-flag tests: 4 carry clear / higher-or-same (C=0), 5 carry set / lower (C=1), 6 not equal (Z=0), 7 equal (Z=1), 8 overflow clear (V=0), 9 overflow set (V=1), 10 plus (N=0), 11 minus (N=1).
- R7: Signed magnitude: 12 greater-or-equal (N==V), 13 less (N!=V), 14 greater (Z=0 and N==V), 15 less-or-equal (Z=1 or N!=V). After a compare of a with b, this matches the signed ordering of a and b.
- R8: The flag input `ccr` has the layout bit5 half carry, bit4 interrupt mask, bit3 N, bit2 Z, bit1 V, bit0 C. Bits 5 and 4 never change `taken` or `pc_out`.
- R9: With `is_long` low, the displacement is `offset[7:0]` sign-extended to 16 bits, and `offset[15:8]` is ignored.
- R10: With `is_long` high, the full 16-bit `offset` is the signed displacement.
- R11: When a request is not taken, `pc_out` equals the `next_pc` of that request.
- R12: A taken target is `next_pc + displacement` modulo 65536, and it wraps with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch request is present this cycle |
| cond_sel | input | 4 | Condition selector, encoded as in R3 to R7 |
| ccr | input | 6 | Condition flags, laid out as in R8 |
| is_long | input | 1 | 1 selects the 16-bit displacement, 0 the 8-bit one |
| next_pc | input | 16 | Address of the instruction after the branch |
| offset | input | 16 | Signed displacement, low byte only in short mode |
| res_valid | output | 1 | Result of the previous cycle's request is present |
| taken | output | 1 | The branch condition held |
| pc_out | output | 16 | Address where execution continues |

## Verification
The condition decision and the address wrap can act on the same request. A taken branch near 0xFFFF with a positive displacement, or near 0x0000 with a negative one, is judged on both its taken flag and its wrapped target in a single comparison. The stimulus also sends requests back to back, so each result is checked in the same cycle the next request is captured. Idle cycles are placed in between to confirm that the outputs hold. For the magnitude tests, the flags are produced in the bench from real subtractions of byte pairs. The selectors are then judged against the integer ordering of those pairs, not against flag formulas.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int ADDR_W   = 16;
    localparam int SHORT_W  = 8;
    localparam int SEL_W    = 4;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int NUM_BASE = NUM_SEL / 2;
    localparam int EXT_W    = ADDR_W - SHORT_W;

    // Flag word, bit 5 down to bit 0
    typedef struct packed {
        logic half;
        logic imask;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    // Even code = test, odd code = its complement
    typedef enum logic [SEL_W-1:0] {
        SEL_ALWAYS = 4'd0,
        SEL_NEVER  = 4'd1,
        SEL_HI     = 4'd2,
        SEL_LS     = 4'd3,
        SEL_CC     = 4'd4,
        SEL_CS     = 4'd5,
        SEL_NE     = 4'd6,
        SEL_EQ     = 4'd7,
        SEL_VC     = 4'd8,
        SEL_VS     = 4'd9,
        SEL_PL     = 4'd10,
        SEL_MI     = 4'd11,
        SEL_GE     = 4'd12,
        SEL_LT     = 4'd13,
        SEL_GT     = 4'd14,
        SEL_LE     = 4'd15
    } cond_sel_e;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [ADDR_W-1:0] pc;
    } bru_state_t;

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic             neg,
    input  logic             zero,
    input  logic             ovf,
    input  logic             carry,
    input  logic [SEL_W-1:0] sel,
    output logic             take
);

    logic [NUM_BASE-1:0] base_test;
    logic [NUM_SEL-1:0]  code_hit;
    logic                sign_agree;

    always_comb begin
        sign_agree   = (neg == ovf);
        base_test[0] = 1'b1;                  // always
        base_test[1] = ~carry & ~zero;        // unsigned higher
        base_test[2] = ~carry;                // carry clear / higher-or-same
        base_test[3] = ~zero;                 // not equal
        base_test[4] = ~ovf;                  // overflow clear
        base_test[5] = ~neg;                  // plus
        base_test[6] = sign_agree;            // signed greater-or-equal
        base_test[7] = ~zero & sign_agree;    // signed greater
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_code
        if (k % 2 == 0) begin : g_even
            assign code_hit[k] = base_test[k/2];
        end else begin : g_odd
            assign code_hit[k] = ~base_test[k/2];
        end
    end

    assign take = code_hit[sel];

endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc
    import bru_pkg::*;
(
    input  logic [ADDR_W-1:0] base_pc,
    input  logic [ADDR_W-1:0] disp,
    input  logic              long_mode,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] disp_sel;

    always_comb begin
        short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        disp_sel  = long_mode ? disp : short_ext;
        // Modulo 2^ADDR_W: carry out of the top bit is discarded
        target    = base_pc + disp_sel;
    end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [5:0]        ccr,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] offset,
    output logic              res_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] pc_out
);

    ccr_t              flags;
    logic              cond_take;
    logic [ADDR_W-1:0] br_target;
    logic              unused_flag_bits;
    bru_state_t        st_d, st_q;

    assign flags            = ccr_t'(ccr);
    assign unused_flag_bits = flags.half ^ flags.imask;

    bru_cond_eval u_cond (
        .neg   (flags.neg),
        .zero  (flags.zero),
        .ovf   (flags.ovf),
        .carry (flags.carry),
        .sel   (cond_sel),
        .take  (cond_take)
    );

    bru_target_calc u_tgt (
        .base_pc   (next_pc),
        .disp      (offset),
        .long_mode (is_long),
        .target    (br_target)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = br_valid;
        if (br_valid) begin
            st_d.taken = cond_take;
            st_d.pc    = cond_take ? br_target : next_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign taken     = st_q.taken;
    assign pc_out    = st_q.pc;

endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk
    import bru_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic [SEL_W-1:0]  cond_sel,
    input logic [5:0]        ccr,
    input logic              is_long,
    input logic [ADDR_W-1:0] next_pc,
    input logic [ADDR_W-1:0] offset,
    input logic              res_valid,
    input logic              taken,
    input logic [ADDR_W-1:0] pc_out
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_valid == $past(br_valid)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> ($stable(taken) && $stable(pc_out)));

    // R3
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cond_sel == 4'd0) |=> taken);

    // R3
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cond_sel == 4'd1) |=> !taken);

    // R11
    fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (pc_out == $past(next_pc)));

    // R10
    long_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && is_long) |=> (taken -> (pc_out == $past(next_pc) + $past(offset))));

    // R7
    signed_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cond_sel == 4'd12 && ccr[3] == ccr[1]) |=> taken);

endmodule

bind bru_unit bru_unit_chk chk_i (.*);

// File: tb/bru_unit_tb.sv
module bru_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid;
    logic [3:0]  cond_sel;
    logic [5:0]  ccr;
    logic        is_long;
    logic [15:0] next_pc;
    logic [15:0] offset;
    logic        res_valid;
    logic        taken;
    logic [15:0] pc_out;

    int n_checks = 0;
    int n_errors = 0;
    bit exp_taken = 1'b0;
    int exp_pc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_unit dut_i (
        .clk, .rst_n, .br_valid, .cond_sel, .ccr, .is_long,
        .next_pc, .offset, .res_valid, .taken, .pc_out
    );

    // Reference decision table written per mnemonic
    function automatic bit ref_take(int code, bit n, bit z, bit v, bit c);
        case (code)
            0:  return 1'b1;
            1:  return 1'b0;
            2:  return (c == 0) && (z == 0);
            3:  return c || z;
            4:  return c == 0;
            5:  return c == 1;
            6:  return z == 0;
            7:  return z == 1;
            8:  return v == 0;
            9:  return v == 1;
            10: return n == 0;
            11: return n == 1;
            12: return n == v;
            13: return n != v;
            14: return (z == 0) && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge
    task automatic request(string req, int code, bit [5:0] f, bit lng,
                           bit [15:0] npc, bit [15:0] off);
        int disp;
        br_valid = 1'b1; cond_sel = code[3:0]; ccr = f;
        is_long = lng; next_pc = npc; offset = off;
        disp = lng ? int'($signed(off)) : int'($signed(off[7:0]));
        exp_taken = ref_take(code, f[3], f[2], f[1], f[0]);
        exp_pc = exp_taken ? ((int'(npc) + disp) & 16'hFFFF) : int'(npc);
        @(negedge clk);
        check(req, int'(res_valid), 1);
        check(req, int'(taken), int'(exp_taken));
        check(req, int'(pc_out), exp_pc);
    endtask

    task automatic idle_cycle(string req);
        br_valid = 1'b0; cond_sel = 4'($urandom); ccr = 6'($urandom);
        is_long = 1'($urandom); next_pc = 16'($urandom); offset = 16'($urandom);
        @(negedge clk);
        check(req, int'(res_valid), 0);
        check(req, int'(taken), int'(exp_taken));
        check(req, int'(pc_out), exp_pc);
    endtask

    // Flags from a byte subtraction a - b: {H,I,N,Z,V,C}
    function automatic bit [5:0] cmp_flags(bit [7:0] a, bit [7:0] b);
        bit [7:0] r;
        bit n, z, v, c;
        r = a - b;
        n = r[7];
        z = (r == 0);
        c = (a < b);
        v = (a[7] != b[7]) && (r[7] != a[7]);
        return {2'b00, n, z, v, c};
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; br_valid = 1'b1; cond_sel = 4'd0; ccr = 6'h3F;
        is_long = 1'b1; next_pc = 16'h1234; offset = 16'h0011;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(res_valid), 0);
        check("R1", int'(taken), 0);
        check("R1", int'(pc_out), 0);
        rst_n = 1'b1;
        br_valid = 1'b0;
        @(negedge clk);
        check("R1", int'(res_valid), 0);
        check("R1", int'(pc_out), 0);

        // R3 always / never
        request("R3", 0, 6'h3F, 1'b0, 16'h2000, 16'h0010);
        request("R3", 1, 6'h00, 1'b0, 16'h2000, 16'h0010);
        request("R3", 1, 6'h3F, 1'b1, 16'h2000, 16'h0010);
        // R2 hold during idle
        idle_cycle("R2");
        idle_cycle("R2");

        // R9 short: upper byte ignored, negative and positive extremes
        request("R9", 0, 6'h00, 1'b0, 16'h4000, 16'hAB7F);
        request("R9", 0, 6'h00, 1'b0, 16'h4000, 16'h5580);
        request("R9", 0, 6'h00, 1'b0, 16'h4000, 16'h00FF);
        // R10 long extremes
        request("R10", 0, 6'h00, 1'b1, 16'h4000, 16'h7FFF);
        request("R10", 0, 6'h00, 1'b1, 16'h4000, 16'h8000);
        // R12 wrap across top and bottom, with condition decision (R7)
        request("R12", 14, 6'h00, 1'b0, 16'hFFF0, 16'h0020);
        request("R12", 13, 6'h08, 1'b0, 16'h0005, 16'h00F0);
        request("R12", 0, 6'h00, 1'b1, 16'hF000, 16'h2000);
        // R11 fall-through with large offset
        request("R11", 7, 6'h00, 1'b1, 16'hBEEF, 16'h1234);
        idle_cycle("R2");

        // R4 R5 R6 R7 R8 exhaustive selector x flag sweep
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 64; f++) begin
                string tag;
                if (code < 2) tag = "R3";
                else if (code < 4) tag = "R5";
                else if (code < 12) tag = "R6";
                else tag = "R7";
                request(tag, code, 6'(f), 1'($urandom),
                        16'($urandom), 16'($urandom));
            end
        end

        // R4 pair complement, R8 H/I bits ignored
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 8; p++) begin
                bit t_even, t_odd;
                request("R4", 2*p, {2'b00, 4'(f)}, 1'b0, 16'h1000, 16'h0004);
                t_even = taken;
                request("R4", 2*p+1, {2'b00, 4'(f)}, 1'b0, 16'h1000, 16'h0004);
                t_odd = taken;
                check("R4", int'(t_even ^ t_odd), 1);
                request("R8", 2*p, {2'b11, 4'(f)}, 1'b0, 16'h1000, 16'h0004);
                check("R8", int'(taken), int'(t_even));
                request("R8", 2*p, {2'b10, 4'(f)}, 1'b0, 16'h1000, 16'h0004);
                check("R8", int'(taken), int'(t_even));
            end
        end

        // R5 R7 judged against real byte comparisons
        for (int i = 0; i < 300; i++) begin
            bit [7:0] a, b;
            bit [5:0] fl;
            a = 8'($urandom); b = (i % 5 == 0) ? a : 8'($urandom);
            fl = cmp_flags(a, b);
            request("R5", 2, fl, 1'b0, 16'h3000, 16'h0002);
            check("R5", int'(taken), int'(a > b));
            request("R5", 3, fl, 1'b0, 16'h3000, 16'h0002);
            check("R5", int'(taken), int'(a <= b));
            request("R6", 5, fl, 1'b0, 16'h3000, 16'h0002);
            check("R6", int'(taken), int'(a < b));
            request("R7", 14, fl, 1'b0, 16'h3000, 16'h0002);
            check("R7", int'(taken), int'($signed(a) > $signed(b)));
            request("R7", 13, fl, 1'b0, 16'h3000, 16'h0002);
            check("R7", int'(taken), int'($signed(a) < $signed(b)));
            request("R7", 15, fl, 1'b0, 16'h3000, 16'h0002);
            check("R7", int'(taken), int'($signed(a) <= $signed(b)));
            if (i % 7 == 0) idle_cycle("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule